// File: doc/BRIEF.md
# Calibration Tone Mismatch Estimator

This block serves offline I/Q calibration of a quadrature-sampled receiver. A calibration tone is injected and the block is armed with a start strobe and the tone's frequency word. From the next valid sample onward it takes a programmable number of time-aligned I and Q samples. Both paths share one valid strobe, so both captures begin on the same sample. Each path is correlated against a local cosine/sine reference at the tone frequency, which yields one complex bin per path.

At the end of the capture the block reports the Q-to-I mismatch in divide-free form: the Q bin times the conjugate of the I bin, and the squared magnitude of the I bin. Software forms the ratio Hq/Hi from these two values. The block also labels each measurement with a training weight. A tone whose frequency lies in the mirror image of the desired band about half the sample rate is a blocker tone. It takes the out-of-band weight, including where the two bands overlap. Every other tone takes the in-band weight. The coefficient regression that consumes these results happens elsewhere.

Top module: `tone_mismatch_est`

## Requirements
- R1: After reset, all result outputs are zero and `done_o` is low.
- R2: A start is accepted only while idle. It latches the tone word, capture length, band edges, sample rate and both weights. The first sample counted is the first valid sample after the start cycle. A sample in the start cycle itself is not counted.
- R3: For the counted sample k, the reference phase is (k * tone word) mod 2^PW. The octant is the top 3 phase bits. The level table per octant 0..7 is {64, 45, 0, -45, -64, -45, 0, 45}. The cosine is the table at the octant and the sine is the table at (octant + 6) mod 8. A bin is the sum of x·cos, with the negated sum of x·sin as its imaginary part.
- R4: The I and Q bins are built from the same set of samples, taken on the same valid strobes.
- R5: A capture counts exactly N valid samples. N = 0 is taken as 1. Cycles with the valid strobe low are skipped.
- R6: The results are mis_re = Qr·Ir + Qi·Ii, mis_im = Qi·Ir − Qr·Ii and ipow = Ir² + Ii², full precision and signed.
- R7: A tone is a blocker when fs − f2 ≤ tone ≤ fs − f1 (inclusive, signed compare). A blocker tone sets `blk_o` = 1 and `wt_o` = out-of-band weight. Every other tone sets `blk_o` = 0 and `wt_o` = in-band weight.
- R8: A tone inside both the desired band and the blocker band is classed as blocker.
- R9: `done_o` is high for exactly one cycle per capture.
- R10: A start during a capture is ignored and the capture runs on with its original settings. The result outputs change only in the cycle `done_o` rises and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one tone |
| tone_fw_i | input | PW | Tone frequency word (phase increment per sample) |
| band_lo_i | input | PW | Desired band lower edge f1 |
| band_hi_i | input | PW | Desired band upper edge f2 |
| samp_rate_i | input | PW | Sample rate fs in the same units |
| wt_in_i | input | WW | In-band weight |
| wt_out_i | input | WW | Out-of-band (blocker) weight |
| n_len_i | input | NW | Samples per capture (0 means 1) |
| smp_vld_i | input | 1 | Valid strobe shared by both sample paths |
| i_smp_i | input | DW | I path sample, signed |
| q_smp_i | input | DW | Q path sample, signed |
| mis_re_o | output | 2*(DW+8+NW)+1 | Real part of Q bin × conj(I bin) |
| mis_im_o | output | 2*(DW+8+NW)+1 | Imaginary part of Q bin × conj(I bin) |
| ipow_o | output | 2*(DW+8+NW)+1 | Squared magnitude of the I bin |
| wt_o | output | WW | Weight chosen for this tone |
| blk_o | output | 1 | Tone classed as blocker |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench uses the default build: 12-bit samples, a 16-bit frequency word and a 10-bit length field. The 16-bit phase lets random tone words visit all eight reference octants within short captures. Capture lengths are kept to 64 samples or fewer, so dozens of tones fit in a short run while the accumulators still see mixed-sign sums. Band edges are chosen so that tones hit both edges of the mirrored band exactly, and so that one configuration overlaps across half the sample rate.

// File: rtl/tme_pkg.sv
package tme_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CAP = 2'd1, ST_DONE = 2'd2} tme_state_e;

  localparam int REF_W = 8;

  // Eight-point reference level per phase octant.
  function automatic logic signed [REF_W-1:0] ref_lvl(input logic [2:0] oct);
    logic signed [REF_W-1:0] v;
    case (oct)
      3'd0: v = 8'sd64;
      3'd1: v = 8'sd45;
      3'd2: v = 8'sd0;
      3'd3: v = -8'sd45;
      3'd4: v = -8'sd64;
      3'd5: v = -8'sd45;
      3'd6: v = 8'sd0;
      default: v = 8'sd45;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/tme_ref_gen.sv
module tme_ref_gen #(
  parameter int PW = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              adv,
  input  logic [PW-1:0]                     fw,
  output logic signed [tme_pkg::REF_W-1:0]  cos_o,
  output logic signed [tme_pkg::REF_W-1:0]  sin_o
);
  logic [PW-1:0] phase;
  logic [2:0]    oct;

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (adv)   phase <= phase + fw;
  end

  assign oct   = phase[PW-1 -: 3];
  assign cos_o = tme_pkg::ref_lvl(oct);
  assign sin_o = tme_pkg::ref_lvl(oct + 3'd6);
endmodule

// File: rtl/tme_bin_acc.sv
module tme_bin_acc #(
  parameter int DW = 12,
  parameter int AW = 30
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              en,
  input  logic signed [DW-1:0]              x,
  input  logic signed [tme_pkg::REF_W-1:0]  c,
  input  logic signed [tme_pkg::REF_W-1:0]  s,
  output logic signed [AW-1:0]              re_o,
  output logic signed [AW-1:0]              im_o
);
  localparam int PRW = DW + tme_pkg::REF_W;

  logic signed [PRW-1:0] pc, ps;
  logic signed [AW-1:0]  pc_x, ps_x;

  assign pc   = x * c;
  assign ps   = x * s;
  assign pc_x = AW'(pc);
  assign ps_x = AW'(ps);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      re_o <= '0;
      im_o <= '0;
    end else if (en) begin
      re_o <= re_o + pc_x;
      im_o <= im_o - ps_x;
    end
  end
endmodule

// File: rtl/tme_band_class.sv
module tme_band_class #(
  parameter int PW = 16,
  parameter int WW = 8
) (
  input  logic [PW-1:0] fw,
  input  logic [PW-1:0] f1,
  input  logic [PW-1:0] f2,
  input  logic [PW-1:0] fs,
  input  logic [WW-1:0] w_in,
  input  logic [WW-1:0] w_out,
  output logic          blk,
  output logic [WW-1:0] wt
);
  localparam int EW = PW + 2;

  logic signed [EW-1:0] lo, hi, fx;

  // Mirror of the desired band about fs/2; blocker test wins on overlap.
  assign lo  = $signed({2'b00, fs}) - $signed({2'b00, f2});
  assign hi  = $signed({2'b00, fs}) - $signed({2'b00, f1});
  assign fx  = $signed({2'b00, fw});
  assign blk = (fx >= lo) && (fx <= hi);
  assign wt  = blk ? w_out : w_in;
endmodule

// File: rtl/tone_mismatch_est.sv
module tone_mismatch_est #(
  parameter int DW = 12,
  parameter int PW = 16,
  parameter int NW = 10,
  parameter int WW = 8,
  localparam int AW = DW + tme_pkg::REF_W + NW,
  localparam int MW = 2 * AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [PW-1:0]        tone_fw_i,
  input  logic [PW-1:0]        band_lo_i,
  input  logic [PW-1:0]        band_hi_i,
  input  logic [PW-1:0]        samp_rate_i,
  input  logic [WW-1:0]        wt_in_i,
  input  logic [WW-1:0]        wt_out_i,
  input  logic [NW-1:0]        n_len_i,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] i_smp_i,
  input  logic signed [DW-1:0] q_smp_i,
  output logic signed [MW-1:0] mis_re_o,
  output logic signed [MW-1:0] mis_im_o,
  output logic signed [MW-1:0] ipow_o,
  output logic [WW-1:0]        wt_o,
  output logic                 blk_o,
  output logic                 done_o
);
  import tme_pkg::*;

  localparam int NPATH = 2;

  tme_state_e       st;
  logic [PW-1:0]    fw_q;
  logic [NW-1:0]    lim_q;
  logic [NW-1:0]    cnt;
  logic             blk_q;
  logic [WW-1:0]    wt_q;
  logic             acc_go;
  logic             take;
  logic             last;

  logic             blk_n;
  logic [WW-1:0]    wt_n;

  logic signed [REF_W-1:0] ref_c, ref_s;
  logic signed [DW-1:0]    smp [NPATH];
  logic signed [AW-1:0]    bre [NPATH];
  logic signed [AW-1:0]    bim [NPATH];

  assign acc_go = (st == ST_IDLE) && start_i;
  assign take   = (st == ST_CAP) && smp_vld_i;
  assign last   = take && (cnt == lim_q - 1'b1);
  assign smp[0] = i_smp_i;
  assign smp[1] = q_smp_i;

  tme_band_class #(.PW(PW), .WW(WW)) u_class (
    .fw    (tone_fw_i),
    .f1    (band_lo_i),
    .f2    (band_hi_i),
    .fs    (samp_rate_i),
    .w_in  (wt_in_i),
    .w_out (wt_out_i),
    .blk   (blk_n),
    .wt    (wt_n)
  );

  tme_ref_gen #(.PW(PW)) u_ref (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_go),
    .adv   (take),
    .fw    (fw_q),
    .cos_o (ref_c),
    .sin_o (ref_s)
  );

  // One correlator per path, both fed on the same strobe.
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    tme_bin_acc #(.DW(DW), .AW(AW)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .clr  (acc_go),
      .en   (take),
      .x    (smp[p]),
      .c    (ref_c),
      .s    (ref_s),
      .re_o (bre[p]),
      .im_o (bim[p])
    );
  end

  // Capture control.
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      fw_q  <= '0;
      lim_q <= NW'(1);
      cnt   <= '0;
      blk_q <= 1'b0;
      wt_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            st    <= ST_CAP;
            fw_q  <= tone_fw_i;
            lim_q <= (n_len_i == '0) ? NW'(1) : n_len_i;
            cnt   <= '0;
            blk_q <= blk_n;
            wt_q  <= wt_n;
          end
        end
        ST_CAP: begin
          if (take) cnt <= cnt + 1'b1;
          if (last) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Divide-free ratio: Q * conj(I) and |I|^2.
  logic signed [2*AW-1:0] p_qr_ir, p_qi_ii, p_qi_ir, p_qr_ii, p_ir_ir, p_ii_ii;
  logic signed [MW-1:0]   re_n, im_n, pw_n;

  assign p_qr_ir = bre[1] * bre[0];
  assign p_qi_ii = bim[1] * bim[0];
  assign p_qi_ir = bim[1] * bre[0];
  assign p_qr_ii = bre[1] * bim[0];
  assign p_ir_ir = bre[0] * bre[0];
  assign p_ii_ii = bim[0] * bim[0];

  assign re_n = MW'(p_qr_ir) + MW'(p_qi_ii);
  assign im_n = MW'(p_qi_ir) - MW'(p_qr_ii);
  assign pw_n = MW'(p_ir_ir) + MW'(p_ii_ii);

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_re_o <= '0;
      mis_im_o <= '0;
      ipow_o   <= '0;
      wt_o     <= '0;
      blk_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= (st == ST_DONE);
      if (st == ST_DONE) begin
        mis_re_o <= re_n;
        mis_im_o <= im_n;
        ipow_o   <= pw_n;
        wt_o     <= wt_q;
        blk_o    <= blk_q;
      end
    end
  end
endmodule

// File: rtl/tme_chk.sv
module tme_chk #(
  parameter int MW = 61,
  parameter int NW = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic                 smp_vld_i,
  input logic                 done_o,
  input logic signed [MW-1:0] mis_re_o,
  input logic signed [MW-1:0] ipow_o,
  input tme_pkg::tme_state_e  st_i,
  input logic [NW-1:0]        cnt_i,
  input logic [NW-1:0]        lim_i
);
  import tme_pkg::*;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(st_i) == ST_DONE);

  p_hold_re_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(mis_re_o) |-> done_o);

  p_hold_pow_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(ipow_o) |-> done_o);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_CAP && start_i && !(smp_vld_i && cnt_i == lim_i - 1'b1)) |=> st_i == ST_CAP);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    st_i == ST_CAP |-> (cnt_i < lim_i && lim_i != '0));
endmodule

bind tone_mismatch_est tme_chk #(.MW(MW), .NW(NW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .smp_vld_i (smp_vld_i),
  .done_o    (done_o),
  .mis_re_o  (mis_re_o),
  .ipow_o    (ipow_o),
  .st_i      (st),
  .cnt_i     (cnt),
  .lim_i     (lim_q)
);

// File: tb/tone_mismatch_est_bench.sv
module tone_mismatch_est_bench;
  localparam int DW = 12;
  localparam int PW = 16;
  localparam int NW = 10;
  localparam int WW = 8;
  localparam int MW = 2 * (DW + 8 + NW) + 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start_i = 1'b0;
  logic [PW-1:0]        tone_fw_i = '0;
  logic [PW-1:0]        band_lo_i = '0;
  logic [PW-1:0]        band_hi_i = '0;
  logic [PW-1:0]        samp_rate_i = '0;
  logic [WW-1:0]        wt_in_i = 8'd3;
  logic [WW-1:0]        wt_out_i = 8'd40;
  logic [NW-1:0]        n_len_i = '0;
  logic                 smp_vld_i = 1'b0;
  logic signed [DW-1:0] i_smp_i = '0;
  logic signed [DW-1:0] q_smp_i = '0;
  logic signed [MW-1:0] mis_re_o, mis_im_o, ipow_o;
  logic [WW-1:0]        wt_o;
  logic                 blk_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tone_mismatch_est #(.DW(DW), .PW(PW), .NW(NW), .WW(WW)) u_tone_mismatch_est (
    .clk(clk), .rst(rst), .start_i(start_i), .tone_fw_i(tone_fw_i),
    .band_lo_i(band_lo_i), .band_hi_i(band_hi_i), .samp_rate_i(samp_rate_i),
    .wt_in_i(wt_in_i), .wt_out_i(wt_out_i), .n_len_i(n_len_i),
    .smp_vld_i(smp_vld_i), .i_smp_i(i_smp_i), .q_smp_i(q_smp_i),
    .mis_re_o(mis_re_o), .mis_im_o(mis_im_o), .ipow_o(ipow_o),
    .wt_o(wt_o), .blk_o(blk_o), .done_o(done_o)
  );

  function automatic int lvl(input int o);
    int t [8] = '{64, 45, 0, -45, -64, -45, 0, 45};
    return t[o % 8];
  endfunction

  function automatic bit is_blk(input int fw, input int f1, input int f2, input int fs);
    return (fw >= fs - f2) && (fw <= fs - f1);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One tone: pct = valid probability in percent; poke = extra start mid-capture.
  task automatic run_tone(input int fw, input int n, input int f1, input int f2,
                          input int fs, input int pct, input bit poke);
    longint ir = 0, ii = 0, qr = 0, qi = 0;
    int neff = (n == 0) ? 1 : n;
    int k = 0;
    int wait_c = 0;
    bit exp_blk = is_blk(fw, f1, f2, fs);
    @(negedge clk);
    tone_fw_i = PW'(fw); n_len_i = NW'(n);
    band_lo_i = PW'(f1); band_hi_i = PW'(f2); samp_rate_i = PW'(fs);
    start_i = 1'b1;
    smp_vld_i = 1'b1;                       // R2: sample in the start cycle is not counted
    i_smp_i = DW'($urandom_range(0, 4095)); q_smp_i = DW'($urandom_range(0, 4095));
    while (k < neff) begin
      int iv, qv, ph, o;
      @(negedge clk);
      start_i = (poke && k == 2) ? 1'b1 : 1'b0;   // R10: ignored during capture
      if (poke && k == 2) begin
        tone_fw_i = PW'(fw + 4321); n_len_i = NW'(1);
        band_lo_i = '0; band_hi_i = '0; samp_rate_i = '0;
      end
      iv = int'($urandom_range(0, 4095)) - 2048;
      qv = int'($urandom_range(0, 4095)) - 2048;
      i_smp_i = DW'(iv); q_smp_i = DW'(qv);
      smp_vld_i = ($urandom_range(0, 99) < pct);
      if (smp_vld_i) begin
        ph = (k * fw) % 65536;
        o  = ph >> 13;
        ir += longint'(iv) * lvl(o);
        ii -= longint'(iv) * lvl(o + 6);
        qr += longint'(qv) * lvl(o);
        qi -= longint'(qv) * lvl(o + 6);
        k++;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    smp_vld_i = 1'b1;                        // R5: extra samples after N are not counted
    i_smp_i = DW'(2047); q_smp_i = DW'(-2048);
    while (!done_o && wait_c < 50) begin
      @(negedge clk);
      smp_vld_i = $urandom_range(0, 1);
      wait_c++;
    end
    chk("R9 done reached", longint'(done_o), 1);
    chk("R6 R3 R4 R5 mis_re", longint'(mis_re_o), qr * ir + qi * ii);
    chk("R6 R3 R4 R5 mis_im", longint'(mis_im_o), qi * ir - qr * ii);
    chk("R6 ipow", longint'(ipow_o), ir * ir + ii * ii);
    chk("R7 R8 blk", longint'(blk_o), longint'(exp_blk));
    chk("R7 weight", longint'(wt_o), exp_blk ? longint'(wt_out_i) : longint'(wt_in_i));
    @(negedge clk);
    smp_vld_i = 1'b0;
    chk("R9 single-cycle done", longint'(done_o), 0);
    chk("R10 hold after done", longint'(mis_re_o), qr * ir + qi * ii);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 mis_re reset", longint'(mis_re_o), 0);
    chk("R1 ipow reset", longint'(ipow_o), 0);
    chk("R1 wt reset", longint'(wt_o), 0);
    chk("R1 done reset", longint'(done_o), 0);
    rst = 1'b0;
    // Directed: band 12000..16000 of fs 40000 -> blocker 24000..28000.
    run_tone(24000, 8, 12000, 16000, 40000, 100, 0);   // R7 lower edge inclusive
    run_tone(28000, 8, 12000, 16000, 40000, 100, 0);   // R7 upper edge inclusive
    run_tone(28001, 8, 12000, 16000, 40000, 100, 0);   // R7 just above
    run_tone(23999, 8, 12000, 16000, 40000, 100, 0);   // R7 just below
    run_tone(14000, 0, 12000, 16000, 40000, 100, 0);   // R5 N=0 means 1
    run_tone(19000, 16, 18000, 23000, 40000, 60, 0);   // R8 overlap -> blocker
    run_tone(22500, 16, 18000, 23000, 40000, 60, 0);   // R8 desired only
    run_tone(9000, 20, 12000, 16000, 40000, 70, 1);    // R10 start mid-capture
    run_tone(8192, 64, 12000, 16000, 40000, 50, 0);    // R3 octant stepping
    for (int t = 0; t < 30; t++) begin
      int f1 = $urandom_range(0, 20000);
      int f2 = f1 + $urandom_range(0, 20000);
      run_tone($urandom_range(0, 65535), $urandom_range(0, 64), f1, f2,
               40000, $urandom_range(30, 100), $urandom_range(0, 3) == 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule